// File: doc/BRIEF.md
# Flag Offset Loader

This block supplies the two threshold values that a FIFO's programmable flags compare against: X, the almost-empty offset, and Y, the almost-full offset. Both are N bits wide for a FIFO of depth 2^N. While reset is held, two select inputs are sampled. The value seen at the last clock edge before reset is released fixes how the offsets are loaded until the next reset.

There are four codes and three methods. Two codes pick a fixed preset. One code takes the offsets from two writes on the write-side data bus. The last code shifts them in as a serial stream, one bit per write-clock edge while an active-low enable is asserted. The serial stream is Y followed by X, each sent most significant bit first, so it is 2*N bits long.

A done flag rises once every offset bit is in place. The surrounding FIFO must hold off ordinary writes until it sees that flag. After done, the offsets are frozen until the next reset.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst` is high, at every clock edge `done_o` is cleared to 0 and `x_o` and `y_o` are cleared to 0.
- R2: The load method is the value of `sel_i` at the last rising clock edge with `rst` high. Changes on `sel_i` after reset release have no effect until the next reset.
- R3: With `sel_i` = 2'b01, the first clock edge after reset release sets `x_o` = `y_o` = 8 and `done_o` = 1.
- R4: With `sel_i` = 2'b10, the first clock edge after reset release sets `x_o` = `y_o` = 64 and `done_o` = 1.
- R5: With `sel_i` = 2'b00 (parallel), the first edge with `wr_en_i` high loads `y_o` from `wr_data_i[N-1:0]`. The second such edge loads `x_o` from `wr_data_i[N-1:0]` and sets `done_o`.
- R6: With `sel_i` = 2'b11 (serial), each edge with `ser_en_n_i` low shifts `ser_bit_i` into the 2*N-bit chain {Y,X}. The first bit becomes the MSB of `y_o` and the last bit the LSB of `x_o`. `done_o` rises on the edge that takes bit 2*N.
- R7: In serial mode, an edge with `ser_en_n_i` high leaves the offsets unchanged, whatever the value on `ser_bit_i`.
- R8: Once `done_o` is 1, it stays 1 and `x_o`/`y_o` stay unchanged under any serial or write activity until reset.
- R9: Inputs that belong to the unselected method are ignored: `wr_en_i` in serial and preset modes, `ser_en_n_i` in parallel and preset modes.
- R10: `done_o` stays 0 while a parallel or serial load is incomplete: after one parallel write, or after fewer than 2*N serial bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset; `sel_i` is sampled while it is high |
| sel_i | input | 2 | Load-method select: 00 parallel, 01 preset 8, 10 preset 64, 11 serial |
| ser_en_n_i | input | 1 | Serial shift enable, active low |
| ser_bit_i | input | 1 | Serial data bit |
| wr_en_i | input | 1 | Write strobe for parallel load |
| wr_data_i | input | BUS_W | Write data bus; the low N bits carry an offset |
| x_o | output | N | Almost-empty offset |
| y_o | output | N | Almost-full offset |
| done_o | output | 1 | All offset bits loaded |

## Verification
The serial path is driven with random offset pairs. Enable-high gaps with random data on the bit line are mixed into each stream, which separates taken bits from ignored ones. Stray write strobes are also mixed in, which shows that the unselected method is ignored. Directed streams cover the ordering corners. A lone leading 1 must land on Y's MSB, a lone trailing 1 on X's LSB, and an all-ones stream must fill both registers. Each preset code is checked with `sel_i` changed after reset release, which shows the select was latched rather than read live. A parallel load with random bus values, including upper bits that must be dropped, is checked after the first write (Y loaded, not done) and after the second. A third write and extra serial pulses follow, and they must leave every output frozen.

// File: rtl/flag_offset_loader_pkg.sv
package flag_offset_loader_pkg;

    typedef enum logic [1:0] {
        LD_PARALLEL  = 2'b00,
        LD_PRESET_LO = 2'b01,
        LD_PRESET_HI = 2'b10,
        LD_SERIAL    = 2'b11
    } load_mode_e;

    localparam int PRESET_LO_VAL = 8;
    localparam int PRESET_HI_VAL = 64;

    // Number of accepted steps that complete a load in a given mode
    function automatic int steps_for(load_mode_e m, int n);
        case (m)
            LD_SERIAL:   return 2 * n;
            LD_PARALLEL: return 2;
            default:     return 1;
        endcase
    endfunction

    function automatic int preset_for(load_mode_e m);
        return (m == LD_PRESET_HI) ? PRESET_HI_VAL : PRESET_LO_VAL;
    endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
    import flag_offset_loader_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_i,
    output load_mode_e mode_o
);
    load_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= load_mode_e'(sel_i);
    end

    assign mode_o = mode_q;

    // R2: method frozen once out of reset
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/ofs_step_counter.sv
module ofs_step_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (step_i && !done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q + 1'b1 == limit_i) done_q <= 1'b1;
        end
    end

    assign count_o = cnt_q;
    assign done_o  = done_q;

    // R8: done never falls without reset
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

    // R10: step count never runs past the limit of the mode
    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit_i);

    // R10: done only together with a full count
    a_r10_done_full: assert property (@(posedge clk) disable iff (rst)
        done_q |-> cnt_q == limit_i);

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import flag_offset_loader_pkg::*;
#(
    parameter int N     = 9,
    parameter int BUS_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sel_i,
    input  logic             ser_en_n_i,
    input  logic             ser_bit_i,
    input  logic             wr_en_i,
    input  logic [BUS_W-1:0] wr_data_i,
    output logic [N-1:0]     x_o,
    output logic [N-1:0]     y_o,
    output logic             done_o
);
    localparam int CHAIN_W = 2 * N;
    localparam int CNT_W   = $clog2(CHAIN_W + 1);

    load_mode_e         mode;
    logic [CNT_W-1:0]   limit;
    logic [CNT_W-1:0]   count;
    logic               done;
    logic               step;
    logic               take;
    logic [N-1:0]       preset_val;
    logic [CHAIN_W-1:0] ofs_q;

    ofs_mode_latch u_mode (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel_i),
        .mode_o (mode)
    );

    always_comb begin
        limit      = CNT_W'(steps_for(mode, N));
        preset_val = N'(preset_for(mode));
        case (mode)
            LD_SERIAL:   step = !ser_en_n_i;
            LD_PARALLEL: step = wr_en_i;
            default:     step = 1'b1;
        endcase
    end

    assign take = step && !done;

    ofs_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step_i  (take),
        .limit_i (limit),
        .count_o (count),
        .done_o  (done)
    );

    // Offset chain: Y in the upper half, X in the lower half
    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (take) begin
            case (mode)
                LD_SERIAL: ofs_q <= {ofs_q[CHAIN_W-2:0], ser_bit_i};
                LD_PARALLEL: begin
                    if (count == '0) ofs_q[CHAIN_W-1:N] <= wr_data_i[N-1:0];
                    else             ofs_q[N-1:0]       <= wr_data_i[N-1:0];
                end
                default: ofs_q <= {preset_val, preset_val};
            endcase
        end
    end

    assign y_o    = ofs_q[CHAIN_W-1:N];
    assign x_o    = ofs_q[N-1:0];
    assign done_o = done;

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !done_o && x_o == '0 && y_o == '0);

    // R8: offsets frozen once loaded
    a_r8_hold_after_done: assert property (@(posedge clk) disable iff (rst)
        done_o |=> $stable(x_o) && $stable(y_o));

    // R7: no shift in serial mode while enable is high
    a_r7_no_shift_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == LD_SERIAL && ser_en_n_i) |=> $stable(ofs_q));

    // R3/R4: preset modes finish on the first edge after reset
    a_r3_preset_done: assert property (@(posedge clk) disable iff (rst)
        (mode == LD_PRESET_LO || mode == LD_PRESET_HI) |=> done_o);

endmodule

// File: tb/flag_offset_loader_bench.sv
`timescale 1ns/1ps
module flag_offset_loader_bench;
    localparam int N     = 9;
    localparam int BUS_W = 36;
    localparam int CW    = 2 * N;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       sel_i = 2'b00;
    logic             ser_en_n_i = 1'b1;
    logic             ser_bit_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [BUS_W-1:0] wr_data_i = '0;
    logic [N-1:0]     x_o, y_o;
    logic             done_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flag_offset_loader #(.N(N), .BUS_W(BUS_W)) u_flag_offset_loader (
        .clk(clk), .rst(rst), .sel_i(sel_i), .ser_en_n_i(ser_en_n_i),
        .ser_bit_i(ser_bit_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .x_o(x_o), .y_o(y_o), .done_o(done_o)
    );

    function automatic int exp_preset(logic [1:0] s);
        return (s == 2'b10) ? 64 : 8;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req, int ex, int ey, int ed);
        chk({req, " x"}, int'(x_o), ex);
        chk({req, " y"}, int'(y_o), ey);
        chk({req, " done"}, int'(done_o), ed);
    endtask

    // drive inputs, then let one rising edge pass; ends at a falling edge
    task automatic cyc(logic en_n, logic b, logic we, logic [BUS_W-1:0] d);
        ser_en_n_i = en_n; ser_bit_i = b; wr_en_i = we; wr_data_i = d;
        @(negedge clk);
    endtask

    task automatic do_reset(logic [1:0] s);
        rst = 1'b1; sel_i = s;
        cyc(1'b1, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        rst = 1'b0;
    endtask

    // noise that must not alter a finished load
    task automatic poke_after_done();
        for (int i = 0; i < 6; i++)
            cyc(1'b0, 1'($urandom), 1'b1, BUS_W'({$urandom, $urandom}));
        cyc(1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic serial_load(logic [CW-1:0] stream, bit gaps);
        for (int i = CW - 1; i >= 0; i--) begin
            if (gaps) begin
                int g = $urandom_range(0, 2);
                for (int k = 0; k < g; k++)
                    cyc(1'b1, 1'($urandom), 1'($urandom), BUS_W'($urandom));
            end
            if (i == 0) chk("R10 serial not done before last bit", int'(done_o), 0);
            cyc(1'b0, stream[i], gaps ? 1'($urandom) : 1'b0, BUS_W'($urandom));
        end
        cyc(1'b1, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);

        // R1: during reset
        rst = 1'b1; sel_i = 2'b01;
        cyc(1'b0, 1'b1, 1'b1, '1);
        chk_all("R1 reset", 0, 0, 0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        rst = 1'b0;

        // R3 preset low, then R2 select change ignored, R8/R9 noise ignored
        sel_i = 2'b11;
        cyc(1'b1, 1'b0, 1'b0, '0);
        chk_all("R3 preset 8", 8, 8, 1);
        poke_after_done();
        chk_all("R8 R9 preset hold", 8, 8, 1);
        chk_all("R2 select latched", 8, 8, 1);

        // R4 preset high
        do_reset(2'b10);
        sel_i = 2'b00;
        cyc(1'b1, 1'b0, 1'b0, '0);
        chk_all("R4 preset 64", 64, 64, 1);
        chk_all("R2 select latched hi", 64, 64, 1);

        // R5 parallel, with serial noise ignored (R9)
        for (int t = 0; t < 3; t++) begin
            logic [BUS_W-1:0] d1, d2;
            d1 = BUS_W'({$urandom, $urandom});
            d2 = BUS_W'({$urandom, $urandom});
            do_reset(2'b00);
            sel_i = 2'b11;
            for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b0, '0);
            chk_all("R9 serial ignored in parallel", 0, 0, 0);
            cyc(1'b1, 1'b0, 1'b1, d1);
            chk_all("R5 R10 first write", 0, int'(d1[N-1:0]), 0);
            cyc(1'b1, 1'b0, 1'b0, '0);
            cyc(1'b1, 1'b0, 1'b1, d2);
            chk_all("R5 second write", int'(d2[N-1:0]), int'(d1[N-1:0]), 1);
            poke_after_done();
            chk_all("R8 parallel hold", int'(d2[N-1:0]), int'(d1[N-1:0]), 1);
        end

        // R6 directed ordering corners
        do_reset(2'b11);
        serial_load(CW'(1) << (CW - 1), 1'b0);
        chk_all("R6 lead bit is Y msb", 0, 1 << (N - 1), 1);
        do_reset(2'b11);
        serial_load(CW'(1), 1'b0);
        chk_all("R6 last bit is X lsb", 1, 0, 1);
        do_reset(2'b11);
        serial_load('1, 1'b0);
        chk_all("R6 all ones", (1 << N) - 1, (1 << N) - 1, 1);
        poke_after_done();
        chk_all("R8 serial hold", (1 << N) - 1, (1 << N) - 1, 1);

        // R6/R7/R9 random streams with gaps and stray writes
        for (int t = 0; t < 8; t++) begin
            logic [CW-1:0] s;
            s = CW'({$urandom, $urandom});
            do_reset(2'b11);
            sel_i = 2'($urandom);
            serial_load(s, 1'b1);
            chk_all("R6 R7 R9 random serial", int'(s[N-1:0]), int'(s[CW-1:N]), 1);
            poke_after_done();
            chk_all("R8 random hold", int'(s[N-1:0]), int'(s[CW-1:N]), 1);
        end

        // R1 reset after a load clears it
        rst = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, '0);
        chk_all("R1 reset after load", 0, 0, 0);
        rst = 1'b0;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule